// File: doc/BRIEF.md
# Instruction Word Prefetch Buffer

This block holds a small set of instruction words close to the fetch unit. Each request carries a 15-bit word address, a flag that marks it as a real fetch or a speculative prefetch, and the privilege mode. If the request's tag matches a held entry, the block returns the stored word. On a miss, it takes the entry that was used least recently and retags it with the request. It then translates the address and returns the word from memory or from a bank of front-panel switch registers. That word is also written into the entry. Only real fetches move an entry to the most-recent position. Speculative requests can still fill entries, but they leave the recency order unchanged.

Before a real fetch reaches the buffer, the block checks it. A jump to word 0 raises a fault. A user-mode fetch from a page whose map entry is zero raises a protection fault. A fetch whose tagged address equals the breakpoint input raises a breakpoint fault. A request that faults changes no state. The lookup, translation and fault decision are combinational within the request cycle. The tag, data and recency registers update on the following clock edge.

Top module: `ifetch_buffer`

## Requirements
- R1: After reset no request hits. With the recency order at reset, successive real-fetch misses fill entries 0, 1, 2, 3 in that order. A fifth distinct address therefore replaces the first one.
- R2: When a request's tag matches a held entry, `word_o` returns the stored word in the same cycle, with `hit_o` and `word_vld_o` high.
- R3: On a miss, `word_o` returns the word read for the translated address in the same cycle, with `hit_o` low. The least-recent entry takes the new tag and the new word at the next edge.
- R4: A real fetch, hit or miss, makes its entry the most recent. A speculative request never changes the order. Successive speculative misses therefore keep replacing the same entry.
- R5: In supervisor mode the tag is {1, address} and the physical address is the request address. In user mode the tag is {0, address}. The same numeric address in the two modes occupies two separate entries.
- R6: In user mode `pt_idx_o` carries address bits [14:10]. The physical address is {`pt_entry_i`, address bits [9:0]} and appears on `mem_addr_o`.
- R7: A physical address below 8 returns switch register n (bits n*48 +: 48 of `sw_regs_i`) in place of `mem_data_i`.
- R8: A real fetch of address 0, in either mode, raises `zero_fault_o`. No word is returned and no state changes.
- R9: A user-mode real fetch whose page-map entry is zero raises `prot_fault_o`, with the page number (address bits [14:10]) on `fault_page_o`. No state changes.
- R10: A real fetch whose tag equals `bkpt_addr_i` raises `bkpt_fault_o` and changes no state. At most one fault is raised, with priority zero-address, then protection, then breakpoint.
- R11: A speculative request never raises a fault and always returns a word.
- R12: Without a request, every output except the translation outputs is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Fetch request present |
| req_addr_i | input | 15 | Word address of the request |
| req_actual_i | input | 1 | 1 = real fetch, 0 = speculative prefetch |
| req_sup_i | input | 1 | Supervisor mode (unmapped addressing) |
| bkpt_addr_i | input | 16 | Breakpoint tag {mode, address} |
| pt_idx_o | output | 5 | Page-map index |
| pt_entry_i | input | 5 | Page-map entry (physical page, 0 = no execute in user mode) |
| mem_addr_o | output | 15 | Physical memory read address |
| mem_data_i | input | 48 | Memory read data, valid in the same cycle |
| sw_regs_i | input | 384 | Eight 48-bit switch registers, register n at bits n*48 +: 48 |
| word_o | output | 48 | Returned instruction word |
| word_vld_o | output | 1 | Word returned this cycle |
| hit_o | output | 1 | Word came from a held entry |
| zero_fault_o | output | 1 | Fetch of address 0 |
| prot_fault_o | output | 1 | User-mode fetch from an unmapped page |
| bkpt_fault_o | output | 1 | Breakpoint match |
| fault_page_o | output | 5 | Page number of a protection fault |

## Verification
Every result for a request is due in the cycle the request is presented: the word, the hit flag, the faults, and the translation outputs. The bench drives inputs at the falling edge and samples all outputs 8 ns later, before the next rising edge. Changes to tags, data and recency only show up on the first request after the next rising edge. The reference model therefore updates its queue-based recency list and tag arrays only after that edge. Each later request is compared against the updated model, so a wrong victim or a recency change that should not have happened shows up as a wrong hit or a wrong word.

// File: rtl/ifb_pkg.sv
`timescale 1ns/1ps
package ifb_pkg;
  localparam int IFB_ENTRIES = 4;
  localparam int IFB_IDX_W   = $clog2(IFB_ENTRIES);
  localparam int IFB_AGE_W   = IFB_ENTRIES * (IFB_ENTRIES - 1) / 2;

  // bit of the pairwise age table for entries lo < hi; set = lo is newer
  function automatic int pair_bit(int lo, int hi);
    return lo * IFB_ENTRIES - (lo * (lo + 1)) / 2 + (hi - lo - 1);
  endfunction
endpackage

// File: rtl/ifb_age.sv
`timescale 1ns/1ps
module ifb_age
  import ifb_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 touch_i,
  input  logic [IFB_IDX_W-1:0] touch_idx_i,
  output logic [IFB_IDX_W-1:0] oldest_o
);
  logic [IFB_AGE_W-1:0]   age_q, age_d;
  logic [IFB_ENTRIES-1:0] loses_all;

  always_comb begin
    for (int i = 0; i < IFB_ENTRIES; i++) begin
      loses_all[i] = 1'b1;
      for (int j = 0; j < IFB_ENTRIES; j++) begin
        if (j > i && age_q[pair_bit(i, j)])  loses_all[i] = 1'b0;
        if (j < i && !age_q[pair_bit(j, i)]) loses_all[i] = 1'b0;
      end
    end
    oldest_o = '0;
    for (int i = IFB_ENTRIES - 1; i >= 0; i--)
      if (loses_all[i]) oldest_o = IFB_IDX_W'(i);
  end

  always_comb begin
    age_d = age_q;
    if (touch_i) begin
      for (int j = 0; j < IFB_ENTRIES; j++) begin
        if (j > int'(touch_idx_i)) age_d[pair_bit(int'(touch_idx_i), j)] = 1'b1;
        if (j < int'(touch_idx_i)) age_d[pair_bit(j, int'(touch_idx_i))] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) age_q <= '0;
    else         age_q <= age_d;
endmodule

// File: rtl/ifb_xlate.sv
`timescale 1ns/1ps
module ifb_xlate #(
  parameter int ADDR_W = 15,
  parameter int OFF_W  = 10,
  localparam int PAGE_W = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sup_i,
  input  logic [PAGE_W-1:0] pt_entry_i,
  output logic [PAGE_W-1:0] pt_idx_o,
  output logic [ADDR_W:0]   tag_o,
  output logic [ADDR_W-1:0] phys_o,
  output logic              unmapped_o
);
  assign pt_idx_o   = addr_i[ADDR_W-1:OFF_W];
  assign tag_o      = {sup_i, addr_i};
  assign phys_o     = sup_i ? addr_i : {pt_entry_i, addr_i[OFF_W-1:0]};
  assign unmapped_o = !sup_i && (pt_entry_i == '0);
endmodule

// File: rtl/ifb_tags.sv
`timescale 1ns/1ps
module ifb_tags
  import ifb_pkg::*;
#(
  parameter int TAG_W  = 16,
  parameter int DATA_W = 48
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [TAG_W-1:0]     look_tag_i,
  output logic                 hit_o,
  output logic [IFB_IDX_W-1:0] hit_idx_o,
  output logic [DATA_W-1:0]    hit_data_o,
  input  logic                 wr_i,
  input  logic [IFB_IDX_W-1:0] wr_idx_i,
  input  logic [DATA_W-1:0]    wr_data_i
);
  logic [TAG_W-1:0]       tag_q [IFB_ENTRIES];
  logic [DATA_W-1:0]      dat_q [IFB_ENTRIES];
  logic [IFB_ENTRIES-1:0] vld_q, match;

  for (genvar g = 0; g < IFB_ENTRIES; g++) begin : g_ent
    assign match[g] = vld_q[g] && (tag_q[g] == look_tag_i);

    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        tag_q[g] <= '0;
        dat_q[g] <= '0;
      end else if (wr_i && wr_idx_i == IFB_IDX_W'(g)) begin
        vld_q[g] <= 1'b1;
        tag_q[g] <= look_tag_i;
        dat_q[g] <= wr_data_i;
      end
  end

  always_comb begin
    hit_idx_o = '0;
    for (int i = IFB_ENTRIES - 1; i >= 0; i--)
      if (match[i]) hit_idx_o = IFB_IDX_W'(i);
  end

  assign hit_o      = |match;
  assign hit_data_o = dat_q[hit_idx_o];
endmodule

// File: rtl/ifetch_buffer.sv
`timescale 1ns/1ps
module ifetch_buffer
  import ifb_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int OFF_W  = 10,
  parameter int DATA_W = 48,
  parameter int N_SW   = 8,
  localparam int PAGE_W = ADDR_W - OFF_W,
  localparam int TAG_W  = ADDR_W + 1,
  localparam int SW_W   = $clog2(N_SW)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic [ADDR_W-1:0]      req_addr_i,
  input  logic                   req_actual_i,
  input  logic                   req_sup_i,
  input  logic [TAG_W-1:0]       bkpt_addr_i,
  output logic [PAGE_W-1:0]      pt_idx_o,
  input  logic [PAGE_W-1:0]      pt_entry_i,
  output logic [ADDR_W-1:0]      mem_addr_o,
  input  logic [DATA_W-1:0]      mem_data_i,
  input  logic [N_SW*DATA_W-1:0] sw_regs_i,
  output logic [DATA_W-1:0]      word_o,
  output logic                   word_vld_o,
  output logic                   hit_o,
  output logic                   zero_fault_o,
  output logic                   prot_fault_o,
  output logic                   bkpt_fault_o,
  output logic [PAGE_W-1:0]      fault_page_o
);
  logic [TAG_W-1:0]     tag;
  logic [ADDR_W-1:0]    phys;
  logic                 unmapped, checked, go, hit;
  logic [IFB_IDX_W-1:0] hit_idx, oldest;
  logic [DATA_W-1:0]    hit_data, fill_word;

  ifb_xlate #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_xlate (
    .addr_i(req_addr_i), .sup_i(req_sup_i), .pt_entry_i(pt_entry_i),
    .pt_idx_o(pt_idx_o), .tag_o(tag), .phys_o(phys), .unmapped_o(unmapped)
  );

  // checks apply to real fetches only; priority zero > protection > breakpoint
  assign checked      = req_i && req_actual_i;
  assign zero_fault_o = checked && (req_addr_i == '0);
  assign prot_fault_o = checked && !zero_fault_o && unmapped;
  assign bkpt_fault_o = checked && !zero_fault_o && !prot_fault_o && (tag == bkpt_addr_i);
  assign fault_page_o = prot_fault_o ? req_addr_i[ADDR_W-1:OFF_W] : '0;
  assign go = req_i && !zero_fault_o && !prot_fault_o && !bkpt_fault_o;

  assign mem_addr_o = phys;
  assign fill_word  = (int'(phys) < N_SW) ? sw_regs_i[int'(phys[SW_W-1:0])*DATA_W +: DATA_W]
                                          : mem_data_i;

  ifb_tags #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_tags (
    .clk_i(clk_i), .rst_ni(rst_ni), .look_tag_i(tag),
    .hit_o(hit), .hit_idx_o(hit_idx), .hit_data_o(hit_data),
    .wr_i(go && !hit), .wr_idx_i(oldest), .wr_data_i(fill_word)
  );

  ifb_age u_age (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .touch_i(go && req_actual_i), .touch_idx_i(hit ? hit_idx : oldest),
    .oldest_o(oldest)
  );

  assign word_vld_o = go;
  assign hit_o      = go && hit;
  assign word_o     = go ? (hit ? hit_data : fill_word) : '0;
endmodule

// File: rtl/ifb_chk.sv
`timescale 1ns/1ps
module ifb_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              req_actual_i,
  input logic              req_sup_i,
  input logic              word_vld_o,
  input logic              hit_o,
  input logic              zero_fault_o,
  input logic              prot_fault_o,
  input logic              bkpt_fault_o
);
  // R10
  one_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({zero_fault_o, prot_fault_o, bkpt_fault_o}));

  // R8
  zero_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && req_actual_i && req_addr_i == '0) |-> (zero_fault_o && !word_vld_o));

  // R11
  spec_no_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !req_actual_i) |-> (word_vld_o && !zero_fault_o && !prot_fault_o && !bkpt_fault_o));

  // R12
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (!word_vld_o && !hit_o && !zero_fault_o && !prot_fault_o && !bkpt_fault_o));

  // R2
  repeat_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_o && $past(word_vld_o) && req_addr_i == $past(req_addr_i)
     && req_sup_i == $past(req_sup_i)) |-> hit_o);
endmodule

bind ifetch_buffer ifb_chk #(.ADDR_W(ADDR_W)) u_ifb_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .req_addr_i(req_addr_i),
  .req_actual_i(req_actual_i), .req_sup_i(req_sup_i), .word_vld_o(word_vld_o),
  .hit_o(hit_o), .zero_fault_o(zero_fault_o), .prot_fault_o(prot_fault_o),
  .bkpt_fault_o(bkpt_fault_o)
);

// File: tb/sim_ifetch_buffer.sv
`timescale 1ns/1ps
module sim_ifetch_buffer;
  logic          clk = 1'b0, rst_ni = 1'b0;
  logic          req = 1'b0, act = 1'b0, sup = 1'b0;
  logic [14:0]   addr = '0;
  logic [15:0]   bkpt = 16'hFFFF;
  logic [4:0]    pt_idx, pt_entry, fpage;
  logic [14:0]   mem_addr;
  logic [47:0]   mem_data, word;
  logic [383:0]  sw_flat;
  logic          vld, hit, zf, pf, bf;
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [47:0] mem_fn(logic [14:0] a);
    return {3'b000, a, 3'b101, a ^ 15'h5555, 12'hC3A};
  endfunction
  function automatic logic [47:0] sw_val(int k);
    return {8'hC0 | 8'(k), 40'h13579BDF02};
  endfunction
  function automatic logic [4:0] pt_val(int p);
    return (p == 0 || p == 3) ? 5'd0 : {1'b1, 4'(p)};
  endfunction

  assign pt_entry = pt_val(int'(pt_idx));
  assign mem_data = mem_fn(mem_addr);
  assign sw_flat  = {sw_val(7), sw_val(6), sw_val(5), sw_val(4),
                     sw_val(3), sw_val(2), sw_val(1), sw_val(0)};

  ifetch_buffer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .req_addr_i(addr),
    .req_actual_i(act), .req_sup_i(sup), .bkpt_addr_i(bkpt),
    .pt_idx_o(pt_idx), .pt_entry_i(pt_entry), .mem_addr_o(mem_addr),
    .mem_data_i(mem_data), .sw_regs_i(sw_flat), .word_o(word),
    .word_vld_o(vld), .hit_o(hit), .zero_fault_o(zf), .prot_fault_o(pf),
    .bkpt_fault_o(bf), .fault_page_o(fpage)
  );

  // reference model: tags, data, validity and a recency list (oldest first)
  logic [15:0] m_tag [4];
  logic [47:0] m_dat [4];
  bit          m_vld [4];
  int          rec_q [$];

  task automatic model_clear();
    for (int k = 0; k < 4; k++) begin m_vld[k] = 0; m_tag[k] = '0; m_dat[k] = '0; end
    rec_q = {0, 1, 2, 3};
  endtask

  task automatic cmp(input string r, input string what, input logic [47:0] a, input logic [47:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", r, what, a, e);
    end
  endtask

  task automatic step(input logic rq, input logic [14:0] a, input logic ac, input logic sp, input string r);
    logic [15:0] tg; logic [14:0] ph; logic [4:0] pg;
    logic ezf, epf, ebf, go, eh; int hi; logic [47:0] fill, ew;
    @(negedge clk);
    req = rq; addr = a; act = ac; sup = sp;
    #8;
    pg  = a[14:10];
    tg  = {sp, a};
    ph  = sp ? a : {pt_val(int'(pg)), a[9:0]};
    ezf = rq && ac && a == 0;
    epf = rq && ac && !ezf && !sp && pt_val(int'(pg)) == 0;
    ebf = rq && ac && !ezf && !epf && tg == bkpt;
    go  = rq && !ezf && !epf && !ebf;
    eh = 0; hi = 0;
    for (int k = 0; k < 4; k++) if (m_vld[k] && m_tag[k] == tg) begin eh = 1; hi = k; end
    fill = (ph < 8) ? sw_val(int'(ph)) : mem_fn(ph);
    ew   = go ? (eh ? m_dat[hi] : fill) : '0;
    cmp(r, "word", word, ew);
    cmp(r, "valid", 48'(vld), 48'(go));
    cmp(r, "hit", 48'(hit), 48'(go && eh));
    cmp(r, "zero_fault", 48'(zf), 48'(ezf));
    cmp(r, "prot_fault", 48'(pf), 48'(epf));
    cmp(r, "bkpt_fault", 48'(bf), 48'(ebf));
    cmp(r, "fault_page", 48'(fpage), 48'(epf ? pg : 5'd0));
    if (rq) begin
      cmp(r, "pt_idx", 48'(pt_idx), 48'(pg));
      cmp(r, "mem_addr", 48'(mem_addr), 48'(ph));
    end
    @(posedge clk); #1;
    if (go) begin
      if (!eh) begin
        hi = rec_q[0];
        m_vld[hi] = 1; m_tag[hi] = tg; m_dat[hi] = fill;
      end
      if (ac) begin
        for (int k = 0; k < rec_q.size(); k++)
          if (rec_q[k] == hi) begin rec_q.delete(k); break; end
        rec_q.push_back(hi);
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    req = 0; rst_ni = 0;
    model_clear();
    repeat (2) @(negedge clk);
    rst_ni = 1;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [14:0] pool [12];
    pool = '{15'h0100, 15'h0200, 15'h0300, 15'h0400, 15'h0005, 15'h1500,
             15'h2222, 15'h0C10, 15'h4321, 15'h0003, 15'h7FFE, 15'h0000};
    model_clear();
    do_reset();
    // R12 idle outputs
    step(0, 15'h0100, 1, 1, "R12");
    // R1 fill order, R3 misses, R2 hit
    step(1, 15'h0100, 1, 1, "R3");
    step(1, 15'h0200, 1, 1, "R3");
    step(1, 15'h0300, 1, 1, "R3");
    step(1, 15'h0400, 1, 1, "R3");
    step(1, 15'h0100, 1, 1, "R2");
    step(1, 15'h0500, 1, 1, "R1");
    step(1, 15'h0200, 1, 1, "R1");
    step(1, 15'h0100, 1, 1, "R2");
    // R4 speculative misses reuse the oldest entry and keep the order
    step(1, 15'h0600, 0, 1, "R4");
    step(1, 15'h0700, 0, 1, "R4");
    step(1, 15'h0600, 0, 1, "R4");
    step(1, 15'h0600, 0, 1, "R4");
    step(1, 15'h0900, 1, 1, "R4");
    step(1, 15'h0600, 1, 1, "R4");
    // R5 separate entries per mode, R6 user translation
    step(1, 15'h1500, 1, 1, "R5");
    step(1, 15'h1500, 1, 0, "R6");
    step(1, 15'h1500, 1, 1, "R5");
    step(1, 15'h1500, 1, 0, "R5");
    step(1, 15'h2A37, 0, 0, "R6");
    // R7 switch registers
    for (int k = 1; k < 8; k++) step(1, 15'(k), k[0], 1, "R7");
    // R8 address zero, R11 speculative bypasses checks
    step(1, 15'h0000, 1, 1, "R8");
    step(1, 15'h0000, 1, 0, "R8");
    step(1, 15'h0000, 0, 1, "R11");
    step(1, 15'h0000, 0, 0, "R11");
    // R9 unmapped user page
    step(1, 15'h0C10, 1, 0, "R9");
    step(1, 15'h0C10, 0, 0, "R11");
    step(1, 15'h0C10, 1, 1, "R9");
    // R10 breakpoint and priority
    bkpt = {1'b1, 15'h2222};
    step(1, 15'h2222, 1, 1, "R10");
    step(1, 15'h2222, 1, 0, "R10");
    step(1, 15'h2222, 0, 1, "R11");
    step(1, 15'h2222, 1, 1, "R10");
    bkpt = {1'b0, 15'h0000};
    step(1, 15'h0000, 1, 0, "R10");
    bkpt = {1'b0, 15'h0C10};
    step(1, 15'h0C10, 1, 0, "R10");
    bkpt = 16'hFFFF;
    // mixed traffic
    for (int n = 0; n < 300; n++)
      step($urandom_range(0, 7) != 0, pool[$urandom_range(0, 11)],
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R4");
    // R1 reset clears the entries
    do_reset();
    step(1, 15'h0100, 1, 1, "R1");
    step(1, 15'h0100, 1, 1, "R2");
    step(0, 15'h0000, 0, 0, "R12");
    done = 1'b1;
    summary();
    $finish;
  end
endmodule